// File: doc/BRIEF.md
# Packed-Lane Vector Rotate Unit

This block executes the two vector rotate operations, rotate-left and rotate-right, on a 64-bit packed word. A 2-bit element-width code splits the word into 8, 16, 32 or 64-bit lanes. Every lane is rotated on its own, and no bit crosses from one lane into the next. The block decodes a 32-bit instruction word itself. From that word it finds the direction and the place the rotate count comes from: the matching lane of a second vector word, a scalar count, or a 6-bit immediate that is split over two fields of the instruction.

The datapath is combinational and ends in one register stage. A result therefore appears one clock after a valid input. When the instruction matches no rotate encoding, the block raises an illegal flag and returns zero. Masking, register-file access, vector length and tail handling belong to the surrounding pipeline.

Top module: `lane_rotate_unit`

## Requirements
- R1: An instruction is recognised only when bits 6:0 equal 1010111. Any other value sets `illegal`.
- R2: For the vector and scalar forms, bits 31:26 pick the direction. 010101 means rotate-left and 010100 means rotate-right. Any other value sets `illegal`.
- R3: Bits 14:12 pick where the count comes from. 000 takes it from the matching lane of `amt_word`, 100 from `scalar_amt`, and 011 from the immediate. Every other value sets `illegal`.
- R4: The immediate form is always a rotate-right. It matches when bits 31:27 equal 01010. Its count is {bit 26, bits 19:15}, zero-extended. When bits 31:27 differ from 01010 under code 011, `illegal` is set.
- R5: `sew_sel` values 0, 1, 2 and 3 select lane widths of 8, 16, 32 and 64 bits.
- R6: The rotate count is reduced modulo the lane width, so only its low log2(width) bits take effect.
- R7: Each lane rotates independently, with no bit crossing a lane boundary. In the vector form, lane i uses the count held in the low bits of lane i of `amt_word`.
- R8: A rotate-right by n gives the same lane value as a rotate-left by (width - n).
- R9: When `illegal` is set, `result` is zero.
- R10: `out_valid`, `result` and `illegal` update one clock after `in_valid` is high. While `in_valid` is low, `result` and `illegal` hold their values and `out_valid` is low on the next clock.
- R11: After reset, `out_valid`, `result` and `illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and instruction are valid this cycle |
| instr | input | 32 | Instruction word |
| src_word | input | 64 | Packed word to be rotated |
| amt_word | input | 64 | Packed per-lane counts for the vector form |
| scalar_amt | input | 6 | Count for the scalar form |
| sew_sel | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64) |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Rotated word, zero when illegal |
| illegal | output | 1 | Instruction matched no rotate encoding |

## Verification
The hardest case to reach is the vector form with different counts in each lane. Here a bit that leaks across a lane boundary, or a count taken from the wrong lane, only shows up when neighbouring lanes hold different counts. The bench drives random count words at every lane width. It checks each lane against an arithmetic model that maps bit positions one by one. It also runs every immediate value, including those with bit 26 set, whose encoding overlaps the rotate-left direction code. Finally, it compares the results of right and left rotates with complementary counts.

// File: rtl/rotu_pkg.sv
package rotu_pkg;
  localparam int MAX_EW = 64;
  localparam int AMT_W = $clog2(MAX_EW);
  localparam int NUM_SEW = 4;

  localparam logic [6:0] OPC_VEC = 7'b1010111;
  localparam logic [5:0] F6_ROL = 6'b010101;
  localparam logic [5:0] F6_ROR = 6'b010100;
  localparam logic [2:0] F3_VV = 3'b000;
  localparam logic [2:0] F3_VX = 3'b100;
  localparam logic [2:0] F3_VI = 3'b011;
  localparam logic [4:0] IMM_HI5 = 5'b01010;

  typedef enum logic [1:0] {
    SRC_VEC = 2'd0,
    SRC_SCL = 2'd1,
    SRC_IMM = 2'd2
  } src_e;

  typedef struct packed {
    logic legal;
    logic dir_left;
    src_e src;
    logic [AMT_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/rotu_decode.sv
module rotu_decode
  import rotu_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [6:0] opc;
  logic [5:0] f6;
  logic [2:0] f3;
  logic       unused_fields;

  assign opc = instr[6:0];
  assign f6  = instr[31:26];
  assign f3  = instr[14:12];
  assign unused_fields = ^{instr[25:20], instr[11:7]};

  always_comb begin
    dec.legal    = 1'b0;
    dec.dir_left = 1'b0;
    dec.src      = SRC_VEC;
    dec.imm      = {instr[26], instr[19:15]};
    if (opc == OPC_VEC) begin
      unique case (f3)
        F3_VV, F3_VX: begin
          dec.src = (f3 == F3_VV) ? SRC_VEC : SRC_SCL;
          if (f6 == F6_ROL) begin
            dec.legal    = 1'b1;
            dec.dir_left = 1'b1;
          end else if (f6 == F6_ROR) begin
            dec.legal    = 1'b1;
          end
        end
        F3_VI: begin
          dec.src = SRC_IMM;
          if (instr[31:27] == IMM_HI5) dec.legal = 1'b1;
        end
        default: dec.legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rotu_lane.sv
module rotu_lane
  import rotu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     data,
  input  logic [W-1:0]     vec_amt,
  input  logic [AMT_W-1:0] scl_amt,
  input  logic [AMT_W-1:0] imm_amt,
  input  src_e             src,
  input  logic             dir_left,
  output logic [W-1:0]     res
);
  localparam int LW = $clog2(W);

  logic [LW-1:0]  raw;
  logic [LW-1:0]  eff;
  logic [2*W-1:0] dbl;
  logic           unused_hi;

  assign unused_hi = ^{vec_amt, scl_amt, imm_amt};

  always_comb begin
    unique case (src)
      SRC_SCL: raw = scl_amt[LW-1:0];
      SRC_IMM: raw = imm_amt[LW-1:0];
      default: raw = vec_amt[LW-1:0];
    endcase
  end

  // a right rotate is turned into a left rotate by the complementary count
  assign eff = dir_left ? raw : (~raw + {{(LW-1){1'b0}}, 1'b1});
  assign dbl = {data, data} << eff;
  assign res = dbl[2*W-1:W];
endmodule

// File: rtl/rotu_lane_array.sv
module rotu_lane_array
  import rotu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int EW     = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] vec_amt,
  input  logic [AMT_W-1:0]  scl_amt,
  input  logic [AMT_W-1:0]  imm_amt,
  input  src_e              src,
  input  logic              dir_left,
  output logic [DATA_W-1:0] res
);
  localparam int NLANE = DATA_W / EW;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    rotu_lane #(.W(EW)) lane_i (
      .data     (data[g*EW +: EW]),
      .vec_amt  (vec_amt[g*EW +: EW]),
      .scl_amt  (scl_amt),
      .imm_amt  (imm_amt),
      .src      (src),
      .dir_left (dir_left),
      .res      (res[g*EW +: EW])
    );
  end
endmodule

// File: rtl/lane_rotate_unit.sv
module lane_rotate_unit
  import rotu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_word,
  input  logic [DATA_W-1:0] amt_word,
  input  logic [AMT_W-1:0]  scalar_amt,
  input  logic [1:0]        sew_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  dec_t dec;
  logic [NUM_SEW-1:0][DATA_W-1:0] rot_all;
  logic [DATA_W-1:0] rot_sel;
  logic [DATA_W-1:0] result_d;
  logic              illegal_d;
  logic              valid_d;

  rotu_decode dec_i (
    .instr (instr),
    .dec   (dec)
  );

  for (genvar k = 0; k < NUM_SEW; k++) begin : g_sew
    rotu_lane_array #(.DATA_W(DATA_W), .EW(8 << k)) arr_i (
      .data     (src_word),
      .vec_amt  (amt_word),
      .scl_amt  (scalar_amt),
      .imm_amt  (dec.imm),
      .src      (dec.src),
      .dir_left (dec.dir_left),
      .res      (rot_all[k])
    );
  end

  always_comb begin
    rot_sel   = rot_all[sew_sel];
    valid_d   = in_valid;
    illegal_d = illegal;
    result_d  = result;
    if (in_valid) begin
      illegal_d = ~dec.legal;
      result_d  = dec.legal ? rot_sel : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= valid_d;
      if (in_valid) begin
        result  <= result_d;
        illegal <= illegal_d;
      end
    end
  end
endmodule

// File: rtl/rotu_checker.sv
module rotu_checker
  import rotu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] src_word,
  input logic [AMT_W-1:0]  scalar_amt,
  input logic [1:0]        sew_sel,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);
  logic opc_ok;
  logic f3_vvx;
  assign opc_ok = instr[6:0] == OPC_VEC;
  assign f3_vvx = (instr[14:12] == F3_VV) || (instr[14:12] == F3_VX);

  assert_opcode_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !opc_ok |=> out_valid && illegal);

  assert_funct6_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opc_ok && f3_vvx && instr[31:26] != F6_ROL && instr[31:26] != F6_ROR
    |=> illegal);

  assert_scalar_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opc_ok && instr[14:12] == F3_VX && instr[31:26] == F6_ROL && scalar_amt == '0
    |=> result == $past(src_word));

  assert_imm_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opc_ok && instr[14:12] == F3_VI && instr[31:27] == IMM_HI5 |=> !illegal);

  assert_imm_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opc_ok && instr[14:12] == F3_VI && instr[31:27] != IMM_HI5 |=> illegal);

  assert_modulo_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opc_ok && instr[14:12] == F3_VX && instr[31:26] == F6_ROR &&
    sew_sel == 2'd0 && scalar_amt[2:0] == 3'd0 |=> result == $past(src_word));

  assert_zero_on_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> result == '0);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(illegal));
endmodule

bind lane_rotate_unit rotu_checker #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .instr      (instr),
  .src_word   (src_word),
  .scalar_amt (scalar_amt),
  .sew_sel    (sew_sel),
  .out_valid  (out_valid),
  .result     (result),
  .illegal    (illegal)
);

// File: tb/lane_rotate_unit_tb_top.sv
module lane_rotate_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] OPC = 7'b1010111;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] src_word;
  logic [63:0] amt_word;
  logic [5:0]  scalar_amt;
  logic [1:0]  sew_sel;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int n_checks = 0;
  int n_fails  = 0;

  lane_rotate_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_word(src_word), .amt_word(amt_word), .scalar_amt(scalar_amt),
    .sew_sel(sew_sel), .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // form: 0 vector lane, 1 scalar, 2 immediate
  function automatic logic [63:0] model(input logic [63:0] src, input logic [63:0] av,
      input logic [5:0] sc, input logic [5:0] imm, input int form, input bit left, input int sew);
    logic [63:0] r = '0;
    int w = 8 << sew;
    for (int l = 0; l < 64 / w; l++) begin
      int base = l * w;
      int n = 0;
      if (form == 0) begin
        for (int b = 0; b < 6 && b < w; b++) n += int'(av[base + b]) << b;
      end else if (form == 1) n = int'(sc);
      else n = int'(imm);
      n = n % w;
      if (!left) n = (w - n) % w;
      for (int j = 0; j < w; j++) r[base + j] = src[base + ((j - n + w) % w)];
    end
    return r;
  endfunction

  function automatic logic [31:0] mk_vx(input bit left, input bit vv);
    return {left ? 6'b010101 : 6'b010100, 1'b1, 5'd3, 5'd7, vv ? 3'b000 : 3'b100, 5'd9, OPC};
  endfunction

  function automatic logic [31:0] mk_vi(input logic [5:0] imm);
    return {5'b01010, imm[5], 1'b1, 5'd4, imm[4:0], 3'b011, 5'd2, OPC};
  endfunction

  task automatic apply(input logic [31:0] ins, input logic [63:0] s, input logic [63:0] a,
                       input logic [5:0] sc, input int sew);
    in_valid   = 1'b1;
    instr      = ins;
    src_word   = s;
    amt_word   = a;
    scalar_amt = sc;
    sew_sel    = 2'(sew);
    @(negedge clk);
  endtask

  task automatic expect_illegal(input string req, input logic [31:0] ins);
    apply(ins, 64'hDEAD_BEEF_0123_4567, 64'h1111_2222_3333_4444, 6'd5, 1);
    check(req, {63'd0, illegal}, 64'd1);
    check("R9", result, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; src_word = '0;
    amt_word = '0; scalar_amt = '0; sew_sel = '0;
    repeat (3) @(negedge clk);
    check("R11", {62'd0, out_valid, illegal}, 64'd0);
    check("R11", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R6: scalar sweep over every count and width, both directions
    for (int sew = 0; sew < 4; sew++)
      for (int dir = 0; dir < 2; dir++)
        for (int n = 0; n < 64; n++) begin
          logic [63:0] s = {$urandom, $urandom};
          apply(mk_vx(dir == 1, 1'b0), s, {$urandom, $urandom}, 6'(n), sew);
          check("R6", result, model(s, '0, 6'(n), '0, 1, dir == 1, sew));
          check("R10", {62'd0, out_valid, illegal}, 64'd2);
        end

    // R4: every immediate at every width, including bit 26 set
    for (int sew = 0; sew < 4; sew++)
      for (int n = 0; n < 64; n++) begin
        logic [63:0] s = {$urandom, $urandom};
        apply(mk_vi(6'(n)), s, '0, 6'd0, sew);
        check("R4", result, model(s, '0, '0, 6'(n), 2, 1'b0, sew));
        check("R4", {63'd0, illegal}, 64'd0);
      end

    // R7: vector form with differing counts per lane
    for (int sew = 0; sew < 4; sew++)
      for (int it = 0; it < 40; it++)
        for (int dir = 0; dir < 2; dir++) begin
          logic [63:0] s = {$urandom, $urandom};
          logic [63:0] a = {$urandom, $urandom};
          apply(mk_vx(dir == 1, 1'b1), s, a, 6'd0, sew);
          check("R7", result, model(s, a, '0, '0, 0, dir == 1, sew));
        end

    // R8: right by n equals left by width-n, compared across two results
    for (int sew = 0; sew < 4; sew++)
      for (int n = 0; n < (8 << sew); n++) begin
        logic [63:0] s = {$urandom, $urandom};
        logic [63:0] r_right;
        apply(mk_vx(1'b0, 1'b0), s, '0, 6'(n), sew);
        r_right = result;
        apply(mk_vx(1'b1, 1'b0), s, '0, 6'(((8 << sew) - n) % 64), sew);
        check("R8", r_right, result);
      end

    // R1 R2 R3 R4 R9: encodings that must be rejected
    expect_illegal("R1", {mk_vx(1'b1, 1'b0)} ^ 32'h0000_0001);
    expect_illegal("R1", {mk_vx(1'b0, 1'b1)[31:7], 7'b0110011});
    expect_illegal("R2", {6'b010110, mk_vx(1'b1, 1'b0)[25:0]});
    expect_illegal("R2", {6'b000000, mk_vx(1'b0, 1'b1)[25:0]});
    expect_illegal("R3", {mk_vx(1'b1, 1'b0)[31:15], 3'b001, mk_vx(1'b1, 1'b0)[11:0]});
    expect_illegal("R3", {mk_vx(1'b0, 1'b0)[31:15], 3'b111, mk_vx(1'b0, 1'b0)[11:0]});
    expect_illegal("R4", {5'b01011, mk_vi(6'd3)[26:0]});
    expect_illegal("R4", {5'b11010, mk_vi(6'd40)[26:0]});

    // R10: hold while idle after a legal result
    apply(mk_vx(1'b1, 1'b0), 64'h0123_4567_89AB_CDEF, '0, 6'd4, 0);
    check("R10", result, model(64'h0123_4567_89AB_CDEF, '0, 6'd4, '0, 1, 1'b1, 0));
    in_valid = 1'b0; instr = 32'hFFFF_FFFF; src_word = '1; scalar_amt = 6'd1;
    @(negedge clk);
    check("R10", {63'd0, out_valid}, 64'd0);
    check("R10", result, model(64'h0123_4567_89AB_CDEF, '0, 6'd4, '0, 1, 1'b1, 0));
    check("R10", {63'd0, illegal}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule